// File: doc/BRIEF.md
# Interrupt Control Register Bank

This block holds one byte-wide control register for each interrupt source of a small controller. Every register carries a three-bit priority level and a pending flag. Level zero also turns the source off. Sources on external pins also carry an edge-select bit. Internal peripheral sources raise their flag on a one-cycle request pulse. Pin sources first pass through a two-flop synchronizer, then through an edge detector. Software can clear a pending flag but can never set one.

The bank reports, for each source, whether that source is both pending and enabled, together with its level. It also reports the highest active level and which source holds it; on a tie the lowest index wins. Vectoring, comparison against the processor's current priority and acknowledge handling are left to the logic that uses these outputs.

Top module: `irq_ctrl_bank`

## Requirements
- R1: Bits 2:0 of every control register hold the priority level (0 to 7) and can be written and read back. A source whose level is 0 is never reported active, even when its flag is set.
- R2: Bit 3 reads 1 while the source has a pending request and 0 otherwise.
- R3: A write with bit 3 equal to 0 clears the pending flag. A write with bit 3 equal to 1 leaves the flag unchanged, so software can never set it.
- R4: A peripheral request input that is high at a rising clock edge sets that source's flag at that edge.
- R5: On pin registers, bit 4 selects the trigger edge: 0 selects falling and 1 selects rising. A pin change sets the flag at the third rising clock edge after the change. An edge of the other polarity has no effect.
- R6: Bits 7:5 of pin registers and bits 7:4 of peripheral registers always read 0, and writes to them have no effect.
- R7: After reset every level, flag and polarity bit is 0, and no source is active.
- R8: When a hardware set and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R9: `top_level` and `top_index` give the highest level among active sources, and a tie goes to the lowest index. With no active source, `top_valid` is 0 and `top_level` and `top_index` are both 0.
- R10: Peripheral sources 0 to 7 sit at addresses 0 to 7, and pin sources 0 to 3 sit at addresses 8 to 11. The source index equals the address. Any other address reads 0, and a write to it changes nothing.
- R11: `src_active[i]` is the AND of source i's flag and a nonzero level, and `src_level` carries each source's level at bits 3i+2:3i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| periph_req | input | 8 | One-cycle request pulses from peripherals |
| pin_in | input | 4 | Asynchronous external interrupt pins |
| src_active | output | 12 | Per-source pending and enabled |
| src_level | output | 36 | Per-source level, 3 bits each |
| top_valid | output | 1 | At least one source active |
| top_level | output | 3 | Highest active level |
| top_index | output | 4 | Index of the source holding top_level |

## Verification
The assertions take for granted that the peripheral request inputs are synchronous to `clk`, since they check a flag in the cycle after a request. They also assume the address is stable whenever the read data is sampled. The bench therefore drives every input, the pins included, on the falling clock edge and samples outputs a little later in that half cycle. It holds pin levels for at least three cycles so that each edge passes through the synchronizer before the next change.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LVL_W    = 3;
  localparam int FLAG_BIT = 3;
  localparam int POL_BIT  = 4;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irqc_pin_edge.sv
module irqc_pin_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;
endmodule

// File: rtl/irqc_src_reg.sv
module irqc_src_reg
  import irqc_pkg::*;
#(
  parameter bit HAS_POL = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [4:0] wr_bits,
  input  logic       set_a,
  input  logic       set_b,
  output logic       flag,
  output lvl_t       level,
  output logic [7:0] rd_byte
);
  lvl_t lvl_q, lvl_d;
  logic flag_q, flag_d;
  logic pol_q, pol_d;
  logic hw_set;

  // Pin sources pick the edge with pol; peripherals use set_a directly.
  assign hw_set = HAS_POL ? (pol_q ? set_a : set_b) : set_a;

  always_comb begin
    lvl_d  = lvl_q;
    pol_d  = pol_q;
    flag_d = flag_q;
    if (wr_en) begin
      lvl_d = wr_bits[LVL_W-1:0];
      pol_d = HAS_POL ? wr_bits[POL_BIT] : 1'b0;
      if (!wr_bits[FLAG_BIT]) flag_d = 1'b0;
    end
    if (hw_set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      flag_q <= 1'b0;
      pol_q  <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      flag_q <= flag_d;
      pol_q  <= pol_d;
    end
  end

  assign flag    = flag_q;
  assign level   = lvl_q;
  assign rd_byte = {3'b000, pol_q, flag_q, lvl_q};
endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick
  import irqc_pkg::*;
#(
  parameter int N_SRC = 12,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]       active,
  input  logic [N_SRC*LVL_W-1:0] levels,
  output logic                   valid,
  output lvl_t                   best_lvl,
  output logic [IDX_W-1:0]       best_idx
);
  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      // Strictly greater keeps the lowest index on a tie.
      if (active[i] && (levels[i*LVL_W +: LVL_W] > best_lvl)) begin
        best_lvl = levels[i*LVL_W +: LVL_W];
        best_idx = IDX_W'(i);
      end
    end
    valid = |active;
  end
endmodule

// File: rtl/irq_ctrl_bank.sv
module irq_ctrl_bank
  import irqc_pkg::*;
#(
  parameter int N_PERIPH = 8,
  parameter int N_PIN    = 4,
  parameter int ADDR_W   = 4,
  localparam int N_SRC   = N_PERIPH + N_PIN,
  localparam int IDX_W   = $clog2(N_SRC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_we,
  input  logic [7:0]             bus_wdata,
  output logic [7:0]             bus_rdata,
  input  logic [N_PERIPH-1:0]    periph_req,
  input  logic [N_PIN-1:0]       pin_in,
  output logic [N_SRC-1:0]       src_active,
  output logic [N_SRC*LVL_W-1:0] src_level,
  output logic                   top_valid,
  output lvl_t                   top_level,
  output logic [IDX_W-1:0]       top_index
);
  logic [N_SRC-1:0] flag_vec;
  logic [N_SRC-1:0] wr_sel;
  logic [7:0]       rd_bytes [N_SRC];
  logic [N_PIN-1:0] pin_rise, pin_fall;
  logic             unused_wr_hi;

  assign unused_wr_hi = ^bus_wdata[7:5];

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_src
      lvl_t lvl;
      assign wr_sel[g] = bus_we && (bus_addr == ADDR_W'(g));
      if (g < N_PERIPH) begin : g_periph
        irqc_src_reg #(.HAS_POL(1'b0)) u_reg (
          .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[g]), .wr_bits(bus_wdata[4:0]),
          .set_a(periph_req[g]), .set_b(1'b0),
          .flag(flag_vec[g]), .level(lvl), .rd_byte(rd_bytes[g])
        );
      end else begin : g_pin
        irqc_pin_edge u_edge (
          .clk(clk), .rst_n(rst_n), .pin(pin_in[g-N_PERIPH]),
          .rise(pin_rise[g-N_PERIPH]), .fall(pin_fall[g-N_PERIPH])
        );
        irqc_src_reg #(.HAS_POL(1'b1)) u_reg (
          .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[g]), .wr_bits(bus_wdata[4:0]),
          .set_a(pin_rise[g-N_PERIPH]), .set_b(pin_fall[g-N_PERIPH]),
          .flag(flag_vec[g]), .level(lvl), .rd_byte(rd_bytes[g])
        );
      end
      assign src_level[g*LVL_W +: LVL_W] = lvl;
      assign src_active[g] = flag_vec[g] && (lvl != '0);
    end
  endgenerate

  always_comb begin
    bus_rdata = 8'h00;
    for (int i = 0; i < N_SRC; i++) begin
      if (bus_addr == ADDR_W'(i)) bus_rdata = rd_bytes[i];
    end
  end

  irqc_prio_pick #(.N_SRC(N_SRC)) u_pick (
    .active(src_active), .levels(src_level),
    .valid(top_valid), .best_lvl(top_level), .best_idx(top_index)
  );
endmodule

// File: rtl/irqc_bank_chk.sv
module irqc_bank_chk
  import irqc_pkg::*;
#(
  parameter int N_PERIPH = 8,
  parameter int N_PIN    = 4,
  parameter int ADDR_W   = 4,
  localparam int N_SRC   = N_PERIPH + N_PIN,
  localparam int IDX_W   = $clog2(N_SRC)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [7:0]          bus_rdata,
  input logic [N_PERIPH-1:0] periph_req,
  input logic [N_SRC-1:0]    flag_vec,
  input logic [N_SRC-1:0]    src_active,
  input logic                top_valid,
  input lvl_t                top_level,
  input logic [IDX_W-1:0]    top_index
);
  // R3: a peripheral flag only rises after a hardware request.
  assert_no_sw_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_vec[N_PERIPH-1:0] & ~$past(flag_vec[N_PERIPH-1:0]) & ~$past(periph_req)) == '0));

  // R4, R8: a request always leaves the flag set, whatever the bus did.
  assert_req_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(periph_req) & ~flag_vec[N_PERIPH-1:0]) == '0));

  // R10: unmapped addresses read zero.
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= ADDR_W'(N_SRC)) |-> (bus_rdata == 8'h00));

  // R6: reserved and unassigned bits of pin registers read zero.
  assert_pin_hi_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= ADDR_W'(N_PERIPH) && bus_addr < ADDR_W'(N_SRC)) |-> (bus_rdata[7:5] == 3'b000));

  // R9: valid agrees with active set; idle outputs are zero.
  assert_valid_any_R9: assert property (@(posedge clk) disable iff (!rst_n)
    top_valid == (src_active != '0));
  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !top_valid |-> (top_level == '0 && top_index == '0));
  assert_valid_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    top_valid |-> (top_level != '0));
endmodule

bind irq_ctrl_bank irqc_bank_chk #(.N_PERIPH(N_PERIPH), .N_PIN(N_PIN), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .periph_req(periph_req), .flag_vec(flag_vec), .src_active(src_active),
  .top_valid(top_valid), .top_level(top_level), .top_index(top_index)
);

// File: tb/irq_ctrl_bank_test.sv
`timescale 1ns/1ps
module irq_ctrl_bank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_we;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [7:0]  periph_req;
  logic [3:0]  pin_in;
  logic [11:0] src_active;
  logic [35:0] src_level;
  logic        top_valid;
  logic [2:0]  top_level;
  logic [3:0]  top_index;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  irq_ctrl_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_req(periph_req),
    .pin_in(pin_in), .src_active(src_active), .src_level(src_level),
    .top_valid(top_valid), .top_level(top_level), .top_index(top_index)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [3:0] a, input logic [7:0] exp);
    bus_addr = a;
    #0.5;
    check(tag, bus_rdata, exp);
  endtask

  task automatic pulse(input int i);
    @(negedge clk);
    periph_req[i] = 1'b1;
    @(negedge clk);
    periph_req[i] = 1'b0;
  endtask

  task automatic top_check(input string tag, input logic v, input int l, input int x);
    #0.5;
    check({tag, " valid"}, top_valid, v);
    check({tag, " level"}, top_level, l);
    check({tag, " index"}, top_index, x);
  endtask

  task automatic t_reset;
    rd_check("R7 periph reg", 4'd0, 8'h00);
    rd_check("R7 pin reg", 4'd8, 8'h00);
    top_check("R7 top", 1'b0, 0, 0);
    check("R7 active", src_active, 0);
  endtask

  task automatic t_fields;
    wr(4'd0, 8'hFF);
    rd_check("R1 R6 periph write ones", 4'd0, 8'h07);
    wr(4'd8, 8'hFF);
    rd_check("R6 pin write ones", 4'd8, 8'h17);
    wr(4'd0, 8'h00);
    wr(4'd8, 8'h00);
    rd_check("R1 level back to 0", 4'd0, 8'h00);
  endtask

  task automatic t_pulse;
    pulse(2);
    rd_check("R2 R4 flag from pulse", 4'd2, 8'h08);
    check("R1 level 0 disables", src_active[2], 0);
    wr(4'd2, 8'h0D);
    rd_check("R3 write 1 keeps flag", 4'd2, 8'h0D);
    #0.5;
    check("R11 active", src_active[2], 1);
    check("R11 level out", src_level[8:6], 5);
    top_check("R9 single", 1'b1, 5, 2);
    wr(4'd2, 8'h05);
    rd_check("R3 write 0 clears", 4'd2, 8'h05);
  endtask

  task automatic t_pin;
    wr(4'd9, 8'h04);
    @(negedge clk); pin_in[1] = 1'b1;
    repeat (4) @(negedge clk);
    rd_check("R5 rise ignored on falling", 4'd9, 8'h04);
    pin_in[1] = 1'b0;
    repeat (2) @(negedge clk);
    rd_check("R5 not before third edge", 4'd9, 8'h04);
    @(negedge clk);
    rd_check("R5 falling sets", 4'd9, 8'h0C);
    wr(4'd9, 8'h14);
    rd_check("R5 R3 clear and pick rising", 4'd9, 8'h14);
    pin_in[1] = 1'b1;
    repeat (3) @(negedge clk);
    rd_check("R5 rising sets", 4'd9, 8'h1C);
    wr(4'd9, 8'h14);
    pin_in[1] = 1'b0;
    repeat (4) @(negedge clk);
    rd_check("R5 fall ignored on rising", 4'd9, 8'h14);
  endtask

  task automatic t_set_wins;
    @(negedge clk);
    periph_req[3] = 1'b1;
    bus_addr = 4'd3; bus_wdata = 8'h02; bus_we = 1'b1;
    @(negedge clk);
    periph_req[3] = 1'b0; bus_we = 1'b0;
    rd_check("R8 set beats clear", 4'd3, 8'h0A);
  endtask

  task automatic t_prio;
    wr(4'd1, 8'h03);
    wr(4'd4, 8'h06);
    wr(4'd9, 8'h16);
    pulse(1);
    pulse(4);
    pin_in[1] = 1'b1;
    repeat (3) @(negedge clk);
    top_check("R9 highest lowest index", 1'b1, 6, 4);
    wr(4'd4, 8'h06);
    top_check("R9 next tied source", 1'b1, 6, 9);
    wr(4'd9, 8'h16);
    top_check("R9 lower level", 1'b1, 3, 1);
    wr(4'd3, 8'h0B);
    top_check("R9 tie to lowest index", 1'b1, 3, 1);
    wr(4'd1, 8'h03);
    top_check("R9 after clear", 1'b1, 3, 3);
    wr(4'd3, 8'h03);
    top_check("R9 none active", 1'b0, 0, 0);
  endtask

  task automatic t_unmapped;
    wr(4'd12, 8'hFF);
    wr(4'd15, 8'hFF);
    rd_check("R10 read unmapped 12", 4'd12, 8'h00);
    rd_check("R10 read unmapped 15", 4'd15, 8'h00);
    rd_check("R10 src1 untouched", 4'd1, 8'h03);
    rd_check("R10 src8 untouched", 4'd8, 8'h00);
    check("R10 nothing active", src_active, 0);
  endtask

  initial begin
    fork
      begin
        #500us;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    join_none
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    periph_req = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_pulse();
    t_pin();
    t_set_wins();
    t_prio();
    t_unmapped();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule